// File: doc/BRIEF.md
# Eight-Line GPIO Controller with Edge Interrupts

This block is an eight-line general-purpose I/O controller with a byte-wide register bus. Lines 0 to 3 are general lines. Lines 4 to 7 can also raise edge interrupts and are numbered as inputs 0 to 3, so the input index is the line number minus four. Every line has a driven value and a direction bit. Reads return the present level of each line.

Each interrupt input passes through a two-flop synchroniser and an edge detector. Rising and falling events go into two separate hidden flags per input. A 2-bit field per input chooses which flag appears in the status register and can drive the single interrupt output. A status write clears both flags of the addressed inputs, whatever trigger is selected. Software gets both-edge behaviour by switching the field after each event.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, `pin_oe` and `pin_out` are 0, `irq` is 0, and the direction, configuration and status registers read 0.
- R2: A write to offset 0 sets `pin_out` to the written byte. A write to offset 1 sets the direction byte, which reads back at offset 1 and drives `pin_oe`; a 1 bit makes that line an output.
- R3: A read at offset 0 returns, per line, the driven value if the line is an output. If the line is an input, it returns the level of `pin_in` after two clock edges.
- R4: Offset 3 holds the configuration byte and reads it back. Input i (line 4+i) uses the field at bits 2i+1:2i.
- R5: A rising or falling edge on an input sets that input's hidden rise or fall flag. The flag sets on the third clock edge after the pin changes, whatever the configuration field holds.
- R6: Status bit i at offset 4 shows the fall flag for field 01, the rise flag for field 10, and 0 for field 00 or 11. Status bits 7:4 read 0.
- R7: `irq` is high whenever any status bit reads 1. It stays high until those bits are cleared or hidden.
- R8: Writing a 1 to status bit i clears both the rise and the fall flag of input i. Bits written 0 are left unchanged.
- R9: An edge that reaches the flags in the same cycle as a clearing write to that input stays latched.
- R10: Offsets 2, 5, 6 and 7 read 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 8 | Line levels seen at the pads |
| pin_out | output | 8 | Driven line values |
| pin_oe | output | 8 | Per-line output enable |
| irq | output | 1 | Parent interrupt |

## Verification
Two events can land on the same input in one cycle: an edge reaching the flags, and a status write that clears them. The bench changes a pin and waits two clock edges. It then issues the clearing write so that the write takes effect on the same edge that latches the event. It judges the result by reading the status register and `irq` afterwards: the bit must still read 1. A second write, with no edge pending, must then clear it.

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] pin_in,
  output logic [7:0] pin_out,
  output logic [7:0] pin_oe,
  output logic       irq
);
  localparam int NOUT = 4;
  localparam int NIN  = 4;

  logic [7:0] sync1_q, sync2_q, prev_q, dout_q, dir_q, cfg_q;
  logic [NIN-1:0] rise_q, fall_q, rise_ev, fall_ev, clr, visible;
  logic wr_dout, wr_dir, wr_cfg, wr_stat;

  assign wr_dout = bus_wr && bus_addr == 3'd0;
  assign wr_dir  = bus_wr && bus_addr == 3'd1;
  assign wr_cfg  = bus_wr && bus_addr == 3'd3;
  assign wr_stat = bus_wr && bus_addr == 3'd4;
  assign clr     = wr_stat ? bus_wdata[NIN-1:0] : '0;

  assign rise_ev = sync2_q[NOUT +: NIN] & ~prev_q[NOUT +: NIN];
  assign fall_ev = ~sync2_q[NOUT +: NIN] & prev_q[NOUT +: NIN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      dout_q  <= '0;
      dir_q   <= '0;
      cfg_q   <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      if (wr_dout) dout_q <= bus_wdata;
      if (wr_dir)  dir_q  <= bus_wdata;
      if (wr_cfg)  cfg_q  <= bus_wdata;
      rise_q <= (rise_q & ~clr) | rise_ev;
      fall_q <= (fall_q & ~clr) | fall_ev;
    end
  end

  for (genvar i = 0; i < NIN; i++) begin : g_vis
    always_comb begin
      case (cfg_q[2*i +: 2])
        2'b01:   visible[i] = fall_q[i];
        2'b10:   visible[i] = rise_q[i];
        default: visible[i] = 1'b0;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = (dout_q & dir_q) | (sync2_q & ~dir_q);
      3'd1:    bus_rdata = dir_q;
      3'd3:    bus_rdata = cfg_q;
      3'd4:    bus_rdata = {{(8-NIN){1'b0}}, visible};
      default: bus_rdata = '0;
    endcase
  end

  assign pin_out = dout_q;
  assign pin_oe  = dir_q;
  assign irq     = |visible;
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] bus_addr,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic [7:0] pin_oe,
  input logic       irq,
  input logic [7:0] sync2_q,
  input logic [7:0] prev_q,
  input logic [7:0] cfg_q,
  input logic [3:0] rise_q,
  input logic [3:0] fall_q
);
  // R2
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd1) |=> pin_oe == $past(bus_wdata));

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(bus_wr && (bus_addr == 3'd3 || bus_addr == 3'd4))) |=> irq);

  // R8
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd4 && bus_wdata[3:0] == 4'hF && sync2_q[7:4] == prev_q[7:4])
    |=> (rise_q == 4'h0 && fall_q == 4'h0));

  // R9
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd4 && bus_wdata[0] && sync2_q[4] && !prev_q[4]) |=> rise_q[0]);

  // R6
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q == 8'h00) |-> !irq);
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .pin_oe(pin_oe), .irq(irq), .sync2_q(sync2_q),
  .prev_q(prev_q), .cfg_q(cfg_q), .rise_q(rise_q), .fall_q(fall_q)
);

// File: tb/tb_gpio_edge_ctrl.sv
module tb_gpio_edge_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe;
  logic       irq;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  gpio_edge_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a;
    bus_wdata = d;
    bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rd(3'd1, d); chk("R1 dir", d, 8'h00);
    rd(3'd3, d); chk("R1 cfg", d, 8'h00);
    rd(3'd4, d); chk("R1 status", d, 8'h00);
  endtask

  task automatic t_dir_data;
    logic [7:0] d;
    wr(3'd1, 8'h0F);
    wr(3'd0, 8'h35);
    chk("R2 pin_oe", pin_oe, 8'h0F);
    chk("R2 pin_out", pin_out, 8'h35);
    rd(3'd1, d); chk("R2 dir readback", d, 8'h0F);
  endtask

  task automatic t_input_read;
    logic [7:0] d;
    pin_in = 8'hAA;
    step(2);
    rd(3'd0, d); chk("R3 mixed level read", d, (8'h35 & 8'h0F) | (8'hAA & 8'hF0));
    wr(3'd1, 8'h00);
    rd(3'd0, d); chk("R3 all inputs", d, 8'hAA);
    wr(3'd1, 8'h0F);
  endtask

  task automatic t_cfg_edges;
    logic [7:0] d;
    step(3);
    wr(3'd4, 8'hFF);
    wr(3'd3, 8'h99);
    rd(3'd3, d); chk("R4 cfg readback", d, 8'h99);
    pin_in = 8'h5A;
    step(3);
    rd(3'd4, d); chk("R6 wrong-edge fields hide flags", d, 8'h00);
    chk("R7 irq low when hidden", {7'b0, irq}, 8'h00);
    wr(3'd3, 8'h66);
    rd(3'd4, d); chk("R5 hidden flags latched", d, 8'h0F);
    chk("R7 irq high", {7'b0, irq}, 8'h01);
    wr(3'd3, 8'hFF);
    rd(3'd4, d); chk("R6 field 11 shows nothing", d, 8'h00);
    wr(3'd3, 8'h66);
  endtask

  task automatic t_clear;
    logic [7:0] d;
    pin_in = 8'h4A;
    step(3);
    wr(3'd4, 8'h01);
    wr(3'd3, 8'h65);
    rd(3'd4, d); chk("R8 both flags of input0 cleared", d, 8'h0E);
    wr(3'd4, 8'h02);
    rd(3'd4, d); chk("R8 zero bits untouched", d, 8'h0C);
    step(5);
    chk("R7 irq held", {7'b0, irq}, 8'h01);
    wr(3'd4, 8'h0C);
    rd(3'd4, d); chk("R8 remaining cleared", d, 8'h00);
    chk("R7 irq drops", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_same_cycle;
    logic [7:0] d;
    wr(3'd3, 8'h02);
    pin_in = 8'h5A;
    step(2);
    wr(3'd4, 8'h01);
    rd(3'd4, d); chk("R9 edge survives clear", d, 8'h01);
    chk("R9 irq", {7'b0, irq}, 8'h01);
    wr(3'd4, 8'h01);
    rd(3'd4, d); chk("R8 clear without edge", d, 8'h00);
  endtask

  task automatic t_unused;
    logic [7:0] d;
    wr(3'd2, 8'hFF);
    wr(3'd5, 8'hFF);
    wr(3'd7, 8'hFF);
    rd(3'd2, d); chk("R10 offset 2 reads 0", d, 8'h00);
    rd(3'd6, d); chk("R10 offset 6 reads 0", d, 8'h00);
    rd(3'd1, d); chk("R10 dir unchanged", d, 8'h0F);
    rd(3'd3, d); chk("R10 cfg unchanged", d, 8'h02);
    chk("R10 pin_out unchanged", pin_out, 8'h35);
  endtask

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_dir_data();
    t_input_read();
    t_cfg_edges();
    t_clear();
    t_same_cycle();
    t_unused();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule